// File: doc/BRIEF.md
# Single-Precision Exponent Extraction Unit

This block accepts one IEEE-754 single-precision operand per cycle and returns floor(log2(|x|)) as a single-precision number. For normal operands this is the unbiased exponent. Subnormal operands are normalised with a leading-one search, which gives exponents from -127 down to -149. NaN, infinity and zero each map to a fixed special result. A denormals-are-zero control input makes subnormal operands behave like zeros.

The unit is a two-stage pipeline. The first stage classifies the operand and forms a signed integer exponent. The second stage applies the special-value results and converts the integer to single precision with no rounding. Two flags travel with each result: one for an invalid operation (a signaling NaN) and one for a subnormal operand that was normalised. A new operand may enter on every cycle.

Top module: `fexp_extract`

## Requirements
- R1: The sign bit of the operand has no effect on the result or the flags of any non-NaN operand: -x and +x give identical outputs.
- R2: For a normal operand (biased exponent field e in bits 30:23, 1 to 254), the result is the integer e-127 in single precision. An integer of 0 encodes as 0x00000000.
- R3: For a NaN operand (field 255, fraction bits 22:0 nonzero), the result is the operand with bit 22 forced to 1, keeping its sign and payload. out_invalid is 1 exactly when bit 22 of the operand was 0 (signaling).
- R4: An infinite operand of either sign (field 255, fraction 0) returns +infinity, 0x7F800000.
- R5: A zero operand returns -infinity, 0xFF800000. A subnormal operand also returns 0xFF800000 when in_daz is 1, and in that case no flag is raised.
- R6: A subnormal operand (field 0, fraction nonzero) with in_daz at 0 returns -149+p, where p is the index of the highest set fraction bit (0 to 22), and raises out_denorm.
- R7: Both flags are 0 for normal, zero and infinite operands. The two flags are never 1 together.
- R8: out_valid is 1 exactly two clock cycles after in_valid was sampled 1, and it is 0 after reset. Operands accepted on consecutive cycles give results on consecutive cycles.
- R9: Every result is an exact single-precision integer value and is never a subnormal encoding. For example, -149 encodes as 0xC3150000 and +127 as 0x42FE0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_valid | input | 1 | Operand strobe |
| in_op | input | 32 | Single-precision operand |
| in_daz | input | 1 | Treat subnormal operands as zero |
| out_valid | output | 1 | Result strobe, two cycles after in_valid |
| out_res | output | 32 | Single-precision exponent result |
| out_invalid | output | 1 | Signaling NaN operand |
| out_denorm | output | 1 | Subnormal operand was normalised |

## Verification
The result of one operand leaves the second stage in the same cycle that the next operand is being classified in the first stage. A fault in the pipeline registers would therefore mix the class, the flags or the DAZ choice of neighbouring operands. The bench provokes this by streaming operands of different classes on back-to-back cycles, including the same subnormal with DAZ off and then on. Each output cycle is compared against the expectation for the operand issued two cycles earlier, with no gap between them.

// File: rtl/fexp_pkg.sv
package fexp_pkg;
  localparam int FP_W    = 32;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int BIAS    = 127;
  localparam int INT_W   = 9;                     // holds -149 .. +127
  localparam int SUB_OFS = BIAS + FRAC_W - 1;     // 149
  localparam logic [FP_W-1:0] POS_INF = 32'h7F80_0000;
  localparam logic [FP_W-1:0] NEG_INF = 32'hFF80_0000;

  typedef enum logic [1:0] {
    CLS_NUM  = 2'd0,
    CLS_NAN  = 2'd1,
    CLS_PINF = 2'd2,
    CLS_NINF = 2'd3
  } fexp_cls_e;

  typedef struct packed {
    fexp_cls_e               cls;
    logic signed [INT_W-1:0] ival;
    logic [FP_W-1:0]         nan;
    logic                    inv;
    logic                    den;
  } fexp_mid_t;
endpackage

// File: rtl/fexp_lead_one.sv
module fexp_lead_one #(
  parameter int W     = 23,
  parameter int IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     vec,
  output logic [IDX_W-1:0] idx
);
  // highest set bit wins; zero vector yields index 0
  always_comb begin
    idx = '0;
    for (int i = 0; i < W; i++) begin
      if (vec[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/fexp_classify.sv
module fexp_classify
  import fexp_pkg::*;
(
  input  logic [FP_W-1:0] op,
  input  logic            daz,
  output fexp_mid_t       mid
);
  localparam int LZ_W = $clog2(FRAC_W);

  logic [EXP_W-1:0]  ef;
  logic [FRAC_W-1:0] frac;
  logic [LZ_W-1:0]   top_bit;

  assign ef   = op[FP_W-2 -: EXP_W];
  assign frac = op[FRAC_W-1:0];

  fexp_lead_one #(.W(FRAC_W), .IDX_W(LZ_W)) u_lead (
    .vec (frac),
    .idx (top_bit)
  );

  always_comb begin
    mid     = '0;
    mid.cls = CLS_NUM;
    if (ef == '1) begin
      if (frac != '0) begin
        mid.cls = CLS_NAN;
        mid.nan = op | (FP_W'(1) << (FRAC_W-1));
        mid.inv = ~frac[FRAC_W-1];
      end else begin
        mid.cls = CLS_PINF;
      end
    end else if (ef == '0) begin
      if ((frac == '0) || daz) begin
        mid.cls = CLS_NINF;
      end else begin
        mid.ival = INT_W'(top_bit) - INT_W'(SUB_OFS);
        mid.den  = 1'b1;
      end
    end else begin
      mid.ival = INT_W'({1'b0, ef}) - INT_W'(BIAS);
    end
  end
endmodule

// File: rtl/fexp_int2fp.sv
module fexp_int2fp
  import fexp_pkg::*;
(
  input  logic signed [INT_W-1:0] ival,
  output logic [FP_W-1:0]         fp
);
  localparam int IDX_W = $clog2(INT_W);
  localparam int SH_W  = $clog2(FRAC_W+1);

  logic [INT_W-1:0]  mag;
  logic [IDX_W-1:0]  msb;
  logic [SH_W-1:0]   shamt;
  logic [FRAC_W:0]   ext;
  logic [FRAC_W:0]   norm;

  assign mag = ival[INT_W-1] ? INT_W'(-ival) : ival;

  fexp_lead_one #(.W(INT_W), .IDX_W(IDX_W)) u_msb (
    .vec (mag),
    .idx (msb)
  );

  assign shamt = SH_W'(FRAC_W) - SH_W'(msb);
  assign ext   = {{(FRAC_W+1-INT_W){1'b0}}, mag};
  assign norm  = ext << shamt;

  // norm[FRAC_W] is the hidden one; it is set exactly when mag is nonzero
  assign fp = norm[FRAC_W]
            ? {ival[INT_W-1], EXP_W'(BIAS) + EXP_W'(msb), norm[FRAC_W-1:0]}
            : '0;
endmodule

// File: rtl/fexp_extract.sv
module fexp_extract
  import fexp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [FP_W-1:0] in_op,
  input  logic            in_daz,
  output logic            out_valid,
  output logic [FP_W-1:0] out_res,
  output logic            out_invalid,
  output logic            out_denorm
);
  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_sync_q;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_q_n = rst_sync_q[1];

  // stage 1: classification
  fexp_mid_t mid_d, mid_q, mid_nx;
  logic      v1_q;

  fexp_classify u_cls (
    .op  (in_op),
    .daz (in_daz),
    .mid (mid_d)
  );

  always_comb begin
    mid_nx = mid_q;
    if (in_valid) mid_nx = mid_d;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      v1_q  <= 1'b0;
      mid_q <= '0;
    end else begin
      v1_q  <= in_valid;
      mid_q <= mid_nx;
    end
  end

  // stage 2: special values and exact conversion
  logic [FP_W-1:0] conv;
  logic [FP_W-1:0] res_d, res_nx;
  logic            inv_nx, den_nx;

  fexp_int2fp u_cvt (
    .ival (mid_q.ival),
    .fp   (conv)
  );

  always_comb begin
    unique case (mid_q.cls)
      CLS_NAN:  res_d = mid_q.nan;
      CLS_PINF: res_d = POS_INF;
      CLS_NINF: res_d = NEG_INF;
      default:  res_d = conv;
    endcase
  end

  always_comb begin
    res_nx = out_res;
    inv_nx = out_invalid;
    den_nx = out_denorm;
    if (v1_q) begin
      res_nx = res_d;
      inv_nx = mid_q.inv;
      den_nx = mid_q.den;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      out_valid   <= 1'b0;
      out_res     <= '0;
      out_invalid <= 1'b0;
      out_denorm  <= 1'b0;
    end else begin
      out_valid   <= v1_q;
      out_res     <= res_nx;
      out_invalid <= inv_nx;
      out_denorm  <= den_nx;
    end
  end
endmodule

// File: rtl/fexp_extract_chk.sv
module fexp_extract_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        out_valid,
  input logic [31:0] out_res,
  input logic        out_invalid,
  input logic        out_denorm
);
  // R8: every accepted operand yields a result two cycles later
  a_r8_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);

  // R7: the flags never fire together
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_invalid && out_denorm));

  // R3: an invalid result is always a quiet NaN
  a_r3_invalid_is_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_invalid) |-> (out_res[30:22] == 9'h1FF));

  // R6: a normalised subnormal gives a negative value in [-149, -127]
  a_r6_denorm_range: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_denorm) |->
      (out_res[31] && (out_res[30:23] == 8'd133 || out_res[30:23] == 8'd134)));

  // R9: no result carries a subnormal encoding
  a_r9_no_subnormal_result: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_res[30:23] != 8'd0) || (out_res[22:0] == 23'd0)));
endmodule

bind fexp_extract fexp_extract_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .in_valid    (in_valid),
  .out_valid   (out_valid),
  .out_res     (out_res),
  .out_invalid (out_invalid),
  .out_denorm  (out_denorm)
);

// File: tb/sim_fexp_extract.sv
module sim_fexp_extract;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] in_op;
  logic        in_daz;
  logic        out_valid;
  logic [31:0] out_res;
  logic        out_invalid;
  logic        out_denorm;

  int total;
  int fails;
  bit done;

  fexp_extract u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .in_op       (in_op),
    .in_daz      (in_daz),
    .out_valid   (out_valid),
    .out_res     (out_res),
    .out_invalid (out_invalid),
    .out_denorm  (out_denorm)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // exact integer -> single precision, derived from the double encoding
  function automatic logic [31:0] int_to_sp(input int v);
    real         r;
    logic [63:0] d;
    logic [10:0] e;
    if (v == 0) return 32'h0;
    r = v;
    d = $realtobits(r);
    e = d[62:52] - 11'd1023 + 11'd127;
    return {d[63], e[7:0], d[51:29]};
  endfunction

  // expected outputs, taken from the requirements
  task automatic model(input logic [31:0] op, input logic daz,
                       output logic [31:0] res, output logic inv, output logic den);
    int p;
    inv = 1'b0;
    den = 1'b0;
    if (op[30:23] == 8'hFF && op[22:0] != 0) begin
      res = op | 32'h0040_0000;
      inv = !op[22];
    end else if (op[30:23] == 8'hFF) begin
      res = 32'h7F80_0000;
    end else if (op[30:23] == 8'h00 && (op[22:0] == 0 || daz)) begin
      res = 32'hFF80_0000;
    end else if (op[30:23] == 8'h00) begin
      p = 0;
      for (int b = 0; b < 23; b++) if (op[b]) p = b;
      res = int_to_sp(p - 149);
      den = 1'b1;
    end else begin
      res = int_to_sp(int'(op[30:23]) - 127);
    end
  endtask

  // single operand: check the strobe timing, the result and the flags
  task automatic one_shot(input logic [31:0] op, input logic daz, input string req);
    logic [31:0] er;
    logic        ei, ed;
    model(op, daz, er, ei, ed);
    @(negedge clk);
    in_valid = 1'b1; in_op = op; in_daz = daz;
    @(negedge clk);
    in_valid = 1'b0; in_op = 32'h0; in_daz = 1'b0;
    chk(out_valid == 1'b0, {req, " R8 early valid"}, 32'(out_valid), 32'd0);
    @(negedge clk);
    chk(out_valid == 1'b1, {req, " R8 valid"}, 32'(out_valid), 32'd1);
    chk(out_res == er, {req, " result"}, out_res, er);
    chk(out_invalid == ei, {req, " R7 invalid flag"}, 32'(out_invalid), 32'(ei));
    chk(out_denorm == ed, {req, " R7 denorm flag"}, 32'(out_denorm), 32'(ed));
    @(negedge clk);
    chk(out_valid == 1'b0, {req, " R8 valid drop"}, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset();
    chk(out_valid == 1'b0, "R8 reset valid", 32'(out_valid), 32'd0);
    chk(out_invalid == 1'b0 && out_denorm == 1'b0, "R7 reset flags",
        {30'd0, out_invalid, out_denorm}, 32'd0);
  endtask

  task automatic t_normals();
    one_shot(32'h3F80_0000, 1'b0, "R2 one gives +0");
    one_shot(32'h4000_0000, 1'b0, "R2 two");
    one_shot(32'h7F7F_FFFF, 1'b0, "R9 largest normal +127");
    one_shot(32'h0080_0000, 1'b0, "R2 smallest normal -126");
    one_shot(32'h3E80_0001, 1'b1, "R2 quarter with DAZ set");
  endtask

  task automatic t_sign();
    one_shot(32'hC000_0000, 1'b0, "R1 negative two");
    one_shot(32'hFF7F_FFFF, 1'b0, "R1 negative largest");
    one_shot(32'h8000_0001, 1'b0, "R1 negative subnormal");
    one_shot(32'h8000_0000, 1'b0, "R1 negative zero");
  endtask

  task automatic t_nan();
    one_shot(32'hFF80_0001, 1'b0, "R3 signaling NaN");
    one_shot(32'h7FC0_1234, 1'b0, "R3 quiet NaN");
    one_shot(32'h7FBF_FFFF, 1'b1, "R3 signaling NaN full payload");
  endtask

  task automatic t_inf();
    one_shot(32'h7F80_0000, 1'b0, "R4 +inf");
    one_shot(32'hFF80_0000, 1'b0, "R4 -inf");
  endtask

  task automatic t_zero_daz();
    one_shot(32'h0000_0000, 1'b0, "R5 zero");
    one_shot(32'h0040_0000, 1'b1, "R5 subnormal with DAZ");
    one_shot(32'h0000_0001, 1'b1, "R5 tiny subnormal with DAZ");
  endtask

  task automatic t_subnormal();
    one_shot(32'h0000_0001, 1'b0, "R6 R9 only bit 0, -149");
    one_shot(32'h0040_0000, 1'b0, "R6 bit 22, -127");
    one_shot(32'h0000_1F00, 1'b0, "R6 bit 12, -137");
    one_shot(32'h0020_0001, 1'b0, "R6 bit 21, -128");
  endtask

  // back-to-back operands of mixed class
  task automatic t_stream();
    localparam int N = 8;
    logic [31:0] sop [N];
    logic        sdz [N];
    logic [31:0] er;
    logic        ei, ed;
    sop[0] = 32'h0000_0100; sdz[0] = 1'b0;
    sop[1] = 32'h0000_0100; sdz[1] = 1'b1;
    sop[2] = 32'h7F80_0001; sdz[2] = 1'b0;
    sop[3] = 32'h4180_0000; sdz[3] = 1'b0;
    sop[4] = 32'h0000_0003; sdz[4] = 1'b0;
    sop[5] = 32'h7FC0_0000; sdz[5] = 1'b1;
    sop[6] = 32'hFF80_0000; sdz[6] = 1'b0;
    sop[7] = 32'h0000_0000; sdz[7] = 1'b0;
    for (int i = 0; i < N + 2; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        model(sop[i-2], sdz[i-2], er, ei, ed);
        chk(out_valid == 1'b1, "R8 stream valid", 32'(out_valid), 32'd1);
        chk(out_res == er, "R8 stream result", out_res, er);
        chk(out_invalid == ei && out_denorm == ed, "R7 stream flags",
            {30'd0, out_invalid, out_denorm}, {30'd0, ei, ed});
      end
      if (i < N) begin
        in_valid = 1'b1; in_op = sop[i]; in_daz = sdz[i];
      end else begin
        in_valid = 1'b0; in_op = 32'h0; in_daz = 1'b0;
      end
    end
    @(negedge clk);
    chk(out_valid == 1'b0, "R8 stream end", 32'(out_valid), 32'd0);
  endtask

  initial begin
    total = 0; fails = 0; done = 1'b0;
    in_valid = 1'b0; in_op = 32'h0; in_daz = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_normals();
    t_sign();
    t_nan();
    t_inf();
    t_zero_daz();
    t_subnormal();
    t_stream();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog expired actual=%08h expected=%08h", 32'd0, 32'd1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule